// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This block lets a host that can only see four 16-bit management registers reach a much larger space of 32-bit internal configuration registers. The host fills in the two data halves, a partial target identifier, and finally a command word. The command word carries the rest of the target identifier, an internal register address, a read flag and a start bit. The bridge assembles the full 6-bit target identifier and runs one transfer on a simple request/acknowledge register bus. It then reports completion through the start bit, which reads back as a status bit.

For a read, the 32-bit result is split back into the two data registers. The host polls the command register until the status bit returns to 1, then reads the halves. The low two target bits only reach the internal bus for two particular upper target values. For every other upper value they are forced to zero.

Top module: `csr_window_bridge`

## Requirements
- R1: After reset, index 0 and index 1 read 0x0000, index 3 reads 0x0000, index 2 reads 0x8000 (status bit set, all command fields zero), and no internal request is raised.
- R2: The host registers are selected by a 2-bit index: 0 is the low data half, 1 is the high data half, 2 is the command word, 3 holds the upper target bits. Index 3 keeps only bits [3:0] and reads 0 above them. Index 2 reads back bits [14:0] exactly as written.
- R3: A host write to index 2 with bit 15 set, while idle, raises the internal request on the next clock. Bit 14 set selects a read (write-enable low); bit 14 clear selects a write. A write to index 2 with bit 15 clear stores the fields and starts nothing.
- R4: The internal target is 6 bits. Bits [5:2] equal index 3 bits [3:0]. Bits [1:0] equal command bits [13:12] when bits [5:2] are 1 or 3, and are 0 for every other value.
- R5: The internal register address equals command bits [10:0].
- R6: For a write transfer the internal write data is {index 1, index 0}.
- R7: When a read transfer is acknowledged, bits [15:0] of the returned word go to index 0 and bits [31:16] go to index 1.
- R8: The request and its address, target, direction and write data hold steady until the acknowledge. The request drops on the clock after the acknowledge. Acknowledge delays of 1 to 64 cycles are handled.
- R9: Command bit 15 reads 0 while a transfer is pending and 1 from the clock after the acknowledge onward. With an acknowledge in the L-th request cycle, it reads 1 exactly L cycles after the cycle in which the request first shows.
- R10: Host writes to any index while a transfer is pending are ignored. A start written then neither alters the running transfer nor queues another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the indexed host register |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_we | output | 1 | Internal bus direction, 1 for write |
| ib_target | output | 6 | Assembled target identifier |
| ib_addr | output | 11 | Internal register address |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal read data, valid with the acknowledge |

## Verification
Some properties are checked on every cycle. The request holds steady with unchanged fields until the acknowledge and falls right after it. The status bit tracks the pending request. The low target bits are zero outside the two allowed upper values. A start issued while idle always raises a request, and a write landing during a pending write leaves the bus fields untouched. The bench covers the rest: it sweeps all 64 target values with mixed directions and acknowledge delays from 1 to 64 cycles. The scenarios are what show the exact data placement, the completion latency, the absence of a queued second transfer, and the reset contents.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 2 * HALF_W;
  localparam int REG_ADDR_W = 11;
  localparam int TGT_HI_W   = 4;
  localparam int TGT_LO_W   = 2;
  localparam int TGT_W      = TGT_HI_W + TGT_LO_W;
  localparam int IDX_W      = 2;

  // command word bit positions
  localparam int CMD_GO_BIT  = 15;
  localparam int CMD_RD_BIT  = 14;
  localparam int CMD_TLO_LSB = 12;

  // upper target values that keep the low target bits
  localparam logic [TGT_HI_W-1:0] KEEP_HI_A = 4'd1;
  localparam logic [TGT_HI_W-1:0] KEEP_HI_B = 4'd3;

  typedef enum logic [IDX_W-1:0] {
    IDX_DLO = 2'd0,
    IDX_DHI = 2'd1,
    IDX_CMD = 2'd2,
    IDX_TGT = 2'd3
  } reg_idx_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/csrb_regfile.sv
module csrb_regfile
  import csrb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic [IDX_W-1:0]      host_addr,
  input  logic [HALF_W-1:0]     host_wdata,
  input  logic                  busy,
  input  logic                  cap_en,
  input  logic [WORD_W-1:0]     cap_data,
  output logic [HALF_W-1:0]     host_rdata,
  output logic [WORD_W-1:0]     wr_word,
  output logic                  cmd_rd,
  output logic [TGT_LO_W-1:0]   cmd_tlo,
  output logic [REG_ADDR_W-1:0] cmd_addr,
  output logic [TGT_HI_W-1:0]   tgt_hi
);
  localparam int CMD_KEEP_W = HALF_W - 1;

  logic [HALF_W-1:0]     dlo_q, dlo_d, dhi_q, dhi_d;
  logic [CMD_KEEP_W-1:0] cmd_q, cmd_d;
  logic [TGT_HI_W-1:0]   tgt_q, tgt_d;
  logic                  dlo_en, dhi_en, cmd_en, tgt_en;
  logic                  wr_ok;

  always_comb begin
    wr_ok  = host_wr && !busy;
    dlo_en = cap_en || (wr_ok && host_addr == IDX_DLO);
    dhi_en = cap_en || (wr_ok && host_addr == IDX_DHI);
    cmd_en = wr_ok && host_addr == IDX_CMD;
    tgt_en = wr_ok && host_addr == IDX_TGT;
    dlo_d  = cap_en ? cap_data[HALF_W-1:0]      : host_wdata;
    dhi_d  = cap_en ? cap_data[WORD_W-1:HALF_W] : host_wdata;
    cmd_d  = host_wdata[CMD_KEEP_W-1:0];
    tgt_d  = host_wdata[TGT_HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo_q <= '0;
      dhi_q <= '0;
      cmd_q <= '0;
      tgt_q <= '0;
    end else begin
      if (dlo_en) dlo_q <= dlo_d;
      if (dhi_en) dhi_q <= dhi_d;
      if (cmd_en) cmd_q <= cmd_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  always_comb begin
    unique case (host_addr)
      IDX_DLO: host_rdata = dlo_q;
      IDX_DHI: host_rdata = dhi_q;
      IDX_CMD: host_rdata = {!busy, cmd_q};
      default: host_rdata = {{(HALF_W-TGT_HI_W){1'b0}}, tgt_q};
    endcase
  end

  assign wr_word  = {dhi_q, dlo_q};
  assign cmd_rd   = cmd_q[CMD_RD_BIT];
  assign cmd_tlo  = cmd_q[CMD_TLO_LSB +: TGT_LO_W];
  assign cmd_addr = cmd_q[REG_ADDR_W-1:0];
  assign tgt_hi   = tgt_q;
endmodule

// File: rtl/csrb_target_map.sv
module csrb_target_map
  import csrb_pkg::*;
(
  input  logic [TGT_HI_W-1:0] tgt_hi,
  input  logic [TGT_LO_W-1:0] tgt_lo_req,
  output logic [TGT_W-1:0]    target
);
  logic keep_lo;

  always_comb begin
    keep_lo = (tgt_hi == KEEP_HI_A) || (tgt_hi == KEEP_HI_B);
    target  = {tgt_hi, keep_lo ? tgt_lo_req : {TGT_LO_W{1'b0}}};
  end
endmodule

// File: rtl/csrb_seq.sv
module csrb_seq
  import csrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              go_bit,
  input  logic              rd_sel,
  input  logic              ib_ack,
  input  logic [WORD_W-1:0] ib_rdata,
  output logic              busy,
  output logic              ib_req,
  output logic              cap_en,
  output logic [WORD_W-1:0] cap_data
);
  seq_state_e state_q, state_d;
  logic       start;

  always_comb begin
    start   = cmd_wr && go_bit && (state_q == ST_IDLE);
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)  state_d = ST_WAIT;
      ST_WAIT: if (ib_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy     = (state_q == ST_WAIT);
  assign ib_req   = busy;
  assign cap_en   = busy && ib_ack && rd_sel;
  assign cap_data = ib_rdata;
endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
  import csrb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic [IDX_W-1:0]      host_addr,
  input  logic [HALF_W-1:0]     host_wdata,
  output logic [HALF_W-1:0]     host_rdata,
  output logic                  ib_req,
  output logic                  ib_we,
  output logic [TGT_W-1:0]      ib_target,
  output logic [REG_ADDR_W-1:0] ib_addr,
  output logic [WORD_W-1:0]     ib_wdata,
  input  logic                  ib_ack,
  input  logic [WORD_W-1:0]     ib_rdata
);
  logic [1:0]            rst_sync_q;
  logic                  rst_ni;
  logic                  busy, cap_en, cmd_rd;
  logic [WORD_W-1:0]     cap_data;
  logic [TGT_LO_W-1:0]   cmd_tlo;
  logic [TGT_HI_W-1:0]   tgt_hi;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  csrb_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .cap_en     (cap_en),
    .cap_data   (cap_data),
    .host_rdata (host_rdata),
    .wr_word    (ib_wdata),
    .cmd_rd     (cmd_rd),
    .cmd_tlo    (cmd_tlo),
    .cmd_addr   (ib_addr),
    .tgt_hi     (tgt_hi)
  );

  csrb_target_map u_tmap (
    .tgt_hi     (tgt_hi),
    .tgt_lo_req (cmd_tlo),
    .target     (ib_target)
  );

  csrb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cmd_wr   (host_wr && host_addr == IDX_CMD),
    .go_bit   (host_wdata[CMD_GO_BIT]),
    .rd_sel   (cmd_rd),
    .ib_ack   (ib_ack),
    .ib_rdata (ib_rdata),
    .busy     (busy),
    .ib_req   (ib_req),
    .cap_en   (cap_en),
    .cap_data (cap_data)
  );

  assign ib_we = !cmd_rd;
endmodule

// File: rtl/csrb_checker.sv
module csrb_checker
  import csrb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_wr,
  input logic [IDX_W-1:0]      host_addr,
  input logic [HALF_W-1:0]     host_wdata,
  input logic [HALF_W-1:0]     host_rdata,
  input logic                  ib_req,
  input logic                  ib_we,
  input logic [TGT_W-1:0]      ib_target,
  input logic [REG_ADDR_W-1:0] ib_addr,
  input logic [WORD_W-1:0]     ib_wdata,
  input logic                  ib_ack
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == IDX_CMD && host_wdata[CMD_GO_BIT] && !ib_req |=> ib_req);

  p_tlo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && ib_target[TGT_W-1:TGT_LO_W] != KEEP_HI_A && ib_target[TGT_W-1:TGT_LO_W] != KEEP_HI_B
    |-> ib_target[TGT_LO_W-1:0] == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ack |=> ib_req && $stable(ib_addr) && $stable(ib_target)
                          && $stable(ib_we) && $stable(ib_wdata));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && ib_ack |=> !ib_req);

  p_busy_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && host_addr == IDX_CMD |-> !host_rdata[CMD_GO_BIT]);

  p_idle_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_req && host_addr == IDX_CMD |-> host_rdata[CMD_GO_BIT]);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && ib_we && host_wr |=> $stable(ib_wdata) && $stable(ib_target)
                                   && $stable(ib_addr) && $stable(ib_we));
endmodule

bind csr_window_bridge csrb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_ni),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .ib_req     (ib_req),
  .ib_we      (ib_we),
  .ib_target  (ib_target),
  .ib_addr    (ib_addr),
  .ib_wdata   (ib_wdata),
  .ib_ack     (ib_ack)
);

// File: tb/csr_window_bridge_tb.sv
`timescale 1ns/1ps
module csr_window_bridge_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [1:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        ib_req, ib_we, ib_ack;
  logic [5:0]  ib_target;
  logic [10:0] ib_addr;
  logic [31:0] ib_wdata, ib_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int          lat_cfg = 1;
  int          req_seen = 0;
  logic [5:0]  obs_tgt;
  logic [10:0] obs_addr;
  logic        obs_we;
  logic [31:0] obs_wdata;

  csr_window_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
    .ib_we(ib_we), .ib_target(ib_target), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] rd_pat(input logic [5:0] t, input logic [10:0] a);
    return {t, 10'h2B5, a, 5'b10101};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] idx, input logic [15:0] d);
    host_addr = idx; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] idx, output logic [15:0] d);
    host_addr = idx;
    #1;
    d = host_rdata;
  endtask

  // internal bus responder
  initial begin
    ib_ack = 1'b0;
    ib_rdata = '0;
    forever begin
      @(negedge clk);
      if (ib_req) begin
        req_seen++;
        obs_tgt = ib_target; obs_addr = ib_addr; obs_we = ib_we; obs_wdata = ib_wdata;
        for (int k = 1; k < lat_cfg; k++) @(negedge clk);
        ib_ack = 1'b1;
        ib_rdata = rd_pat(ib_target, ib_addr);
        @(negedge clk);
        ib_ack = 1'b0;
      end
    end
  end

  // poll until the status bit is 1; returns cycles waited
  task automatic wait_done(output int cyc);
    logic [15:0] v;
    cyc = 0;
    host_read(2'd2, v);
    while (!v[15] && cyc < 200) begin
      @(negedge clk);
      cyc++;
      host_read(2'd2, v);
    end
  endtask

  task automatic run_access(input logic [5:0] tgt, input logic [10:0] a, input bit rd,
                            input logic [31:0] wd, input int lat);
    logic [15:0] v, lo, hi;
    logic [5:0]  exp_t;
    int          cyc;
    int          seen0;
    lat_cfg = lat;
    host_write(2'd0, wd[15:0]);
    host_write(2'd1, wd[31:16]);
    host_write(2'd3, {12'h000, tgt[5:2]});
    seen0 = req_seen;
    host_write(2'd2, {1'b1, rd, tgt[1:0], 1'b0, a});
    host_read(2'd2, v);
    check(v[15] == 1'b0, "R9 status busy after start", {16'h0, v}, 32'h0);
    wait_done(cyc);
    check(cyc == lat, "R9 R8 completion latency", cyc, lat);
    check(req_seen == seen0 + 1, "R3 one request per start", req_seen, seen0 + 1);
    exp_t = (tgt[5:2] == 4'd1 || tgt[5:2] == 4'd3) ? tgt : {tgt[5:2], 2'b00};
    check(obs_tgt == exp_t, "R4 target assembly", {26'h0, obs_tgt}, {26'h0, exp_t});
    check(obs_addr == a, "R5 register address", {21'h0, obs_addr}, {21'h0, a});
    check(obs_we == !rd, "R3 direction", {31'h0, obs_we}, {31'h0, !rd});
    if (!rd) begin
      check(obs_wdata == wd, "R6 write data", obs_wdata, wd);
    end else begin
      host_read(2'd0, lo);
      host_read(2'd1, hi);
      check({hi, lo} == rd_pat(exp_t, a), "R7 read data halves", {hi, lo}, rd_pat(exp_t, a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired R1..R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, lo, hi;
    int seen0;
    int cyc;
    host_wr = 0; host_addr = 0; host_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset contents
    host_read(2'd0, v); check(v == 16'h0000, "R1 reset low data", {16'h0, v}, 32'h0);
    host_read(2'd1, v); check(v == 16'h0000, "R1 reset high data", {16'h0, v}, 32'h0);
    host_read(2'd2, v); check(v == 16'h8000, "R1 reset command", {16'h0, v}, 32'h8000);
    host_read(2'd3, v); check(v == 16'h0000, "R1 reset target", {16'h0, v}, 32'h0);
    check(ib_req == 1'b0, "R1 no request after reset", {31'h0, ib_req}, 32'h0);

    // R2 readback
    host_write(2'd3, 16'hFFFF);
    host_read(2'd3, v); check(v == 16'h000F, "R2 target reg width", {16'h0, v}, 32'h000F);
    host_write(2'd0, 16'h1234);
    host_write(2'd1, 16'hABCD);
    host_read(2'd0, v); check(v == 16'h1234, "R2 low data readback", {16'h0, v}, 32'h1234);
    host_read(2'd1, v); check(v == 16'hABCD, "R2 high data readback", {16'h0, v}, 32'hABCD);

    // R3 command without start bit
    seen0 = req_seen;
    host_write(2'd2, 16'h4123);
    repeat (6) @(negedge clk);
    check(req_seen == seen0, "R3 no start without bit 15", req_seen, seen0);
    host_read(2'd2, v); check(v == 16'hC123, "R2 R3 command readback", {16'h0, v}, 32'hC123);

    // sweep of all 64 targets, mixed directions and delays 1..64
    for (int i = 0; i < 64; i++) begin
      run_access(i[5:0], 11'((i * 37 + 5) & 11'h7FF), i[0],
                 32'h1357_9BDF ^ (i * 32'h0101_0101), (i * 13) % 64 + 1);
    end

    // R10 writes during a pending write transfer are ignored
    lat_cfg = 20;
    host_write(2'd0, 16'h5A5A);
    host_write(2'd1, 16'hC3C3);
    host_write(2'd3, 16'h0003);
    seen0 = req_seen;
    host_write(2'd2, 16'h9ABC);  // go, write, tlo=1, addr 0x2BC... bit 11 set too
    host_write(2'd0, 16'hDEAD);
    host_write(2'd1, 16'hBEEF);
    host_write(2'd3, 16'h000E);
    host_write(2'd2, 16'hC7FF);
    wait_done(cyc);
    repeat (10) @(negedge clk);
    check(req_seen == seen0 + 1, "R10 no queued transfer", req_seen, seen0 + 1);
    check(obs_wdata == 32'hC3C3_5A5A, "R10 write data unchanged", obs_wdata, 32'hC3C3_5A5A);
    check(obs_tgt == 6'd13, "R10 R4 target unchanged", {26'h0, obs_tgt}, 32'd13);
    check(obs_addr == 11'h2BC, "R10 R5 address unchanged", {21'h0, obs_addr}, 32'h2BC);
    host_read(2'd0, lo); check(lo == 16'h5A5A, "R10 low data kept", {16'h0, lo}, 32'h5A5A);
    host_read(2'd1, hi); check(hi == 16'hC3C3, "R10 high data kept", {16'h0, hi}, 32'hC3C3);
    host_read(2'd3, v);  check(v == 16'h0003, "R10 target reg kept", {16'h0, v}, 32'h3);
    host_read(2'd2, v);  check(v == 16'h9ABC, "R10 command kept", {16'h0, v}, 32'h9ABC);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule